// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter built from identical 4-bit stages. Every state bit is updated on the rising edge of one shared clock. A stage can be preset from parallel data inputs, and it clears to zero as soon as its active-low clear input goes low, without waiting for a clock edge. Each stage has two count enables with different jobs. The parallel enable gates counting only. The trickle enable gates counting and also gates the stage's carry-out.

The top module chains a parameter-chosen number of stages into one wider counter, with no gating between them. The lowest stage has its trickle enable tied high. Each stage's carry-out drives the trickle enable of the stage above it. All stages share the clock, clear, load and parallel enable. The carry-out of the highest stage is the block's terminal-count output, and it can drive a further chain.

Top module: `bin_count_chain`

## Requirements
- R1: While `clr_n` is low, `count_o` is zero. The clear takes effect at once, without a clock edge, and overrides load and enable.
- R2: At a rising edge with `clr_n` high and `load_n` low, `count_o` takes the value of `data_i`, whatever the level of `en_p`.
- R3: At a rising edge with `clr_n` high, `load_n` high and `en_p` high, `count_o` increases by one.
- R4: At a rising edge with `clr_n` high, `load_n` high and `en_p` low, `count_o` keeps its value.
- R5: Counting from the all-ones value wraps `count_o` to zero.
- R6: `carry_o` is high exactly when `count_o` is all ones. It follows the count in the same cycle, and `en_p` has no effect on it.
- R7: When a lower stage rolls over from 15, the stage above it advances at the same clock edge. A stage holding 15 does not raise its carry while any stage below it is below 15. For example, with two stages, 0x0F counts to 0x10, and 0xF0 gives `carry_o` low.
- R8: A clear held low across a rising edge keeps `count_o` at zero even when `load_n` is low at that edge.
- R9: Changing `load_n` or `en_p` between rising edges does not change `count_o` until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all stages update on its rising edge |
| clr_n | input | 1 | Active-low asynchronous clear |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_p | input | 1 | Count enable shared by all stages; does not affect carry |
| data_i | input | STAGES*DIGIT_W (8) | Preset value, lowest stage in the low bits |
| count_o | output | STAGES*DIGIT_W (8) | Current count |
| carry_o | output | 1 | Terminal-count carry of the highest stage |

## Verification
The hardest case to reach is the clear that arrives in the middle of a clock period. It must zero the count at once, and it must then beat a load that is pending at the following edge. The stimulus drops `clr_n` between edges, checks `count_o` a moment later, and holds `load_n` low with fresh data across one edge while the clear stays low. Carry masking across stages needs a preset to a value whose upper stage is 15 and whose lower stage is not. The bench reaches this with a load, then counts across the 0x0F and 0xFF boundaries.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_LOAD = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/cnt_op_sel.sv
module cnt_op_sel
  import cnt_pkg::*;
(
  input  logic    load_n,
  input  logic    en_p,
  input  logic    en_t,
  output cnt_op_e op
);
  // load outranks both enables; counting needs both enables high
  always_comb begin
    if (!load_n)            op = OP_LOAD;
    else if (en_p && en_t)  op = OP_INC;
    else                    op = OP_HOLD;
  end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               clr_n,
  input  logic               load_n,
  input  logic               en_p,
  input  logic               en_t,
  input  logic [DIGIT_W-1:0] d,
  output logic [DIGIT_W-1:0] q,
  output logic               carry
);
  cnt_op_e op;

  cnt_op_sel u_sel (
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .op     (op)
  );

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q <= '0;
    end else begin
      case (op)
        OP_LOAD: q <= d;
        OP_INC:  q <= q + 1'b1;
        default: q <= q;
      endcase
    end
  end

  // carry follows the state with no register; en_p takes no part
  assign carry = en_t & (&q);

  AST_CLEAR_ZERO: assert property (@(posedge clk)
    !clr_n |-> q == '0);                                             // R1
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(d));                                      // R2
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t) |=> q == DIGIT_W'($past(q) + 1'b1));    // R3
  AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_p && en_t)) |=> $stable(q));                     // R4
endmodule

// File: rtl/bin_count_chain.sv
module bin_count_chain #(
  parameter int DIGIT_W = 4,
  parameter int STAGES  = 2
) (
  input  logic                       clk,
  input  logic                       clr_n,
  input  logic                       load_n,
  input  logic                       en_p,
  input  logic [STAGES*DIGIT_W-1:0]  data_i,
  output logic [STAGES*DIGIT_W-1:0]  count_o,
  output logic                       carry_o
);
  localparam int TOTAL_W = STAGES * DIGIT_W;

  logic [STAGES-1:0] trickle;
  logic [STAGES-1:0] carry_s;

  assign trickle[0] = 1'b1;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g > 0) begin : g_link
      assign trickle[g] = carry_s[g-1];
    end
    cnt_stage #(.DIGIT_W(DIGIT_W)) u_stage (
      .clk    (clk),
      .clr_n  (clr_n),
      .load_n (load_n),
      .en_p   (en_p),
      .en_t   (trickle[g]),
      .d      (data_i[g*DIGIT_W +: DIGIT_W]),
      .q      (count_o[g*DIGIT_W +: DIGIT_W]),
      .carry  (carry_s[g])
    );
  end

  assign carry_o = carry_s[STAGES-1];

  AST_CARRY_FULL: assert property (@(posedge clk) disable iff (!clr_n)
    carry_o == (count_o == {TOTAL_W{1'b1}}));                        // R6
  AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p) |=> count_o == TOTAL_W'($past(count_o) + 1'b1)); // R7
endmodule

// File: tb/bin_count_chain_test.sv
module bin_count_chain_test;
  logic       clk = 1'b0;
  logic       clr_n, load_n, en_p;
  logic [7:0] data_i;
  logic [7:0] count_o;
  logic       carry_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [7:0] model = 8'h00;

  bin_count_chain #(.DIGIT_W(4), .STAGES(2)) uut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p),
    .data_i(data_i), .count_o(count_o), .carry_o(carry_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference: clear first, then load, then count, then hold
  always @(posedge clk or negedge clr_n) begin
    if (!clr_n)        model <= 8'h00;
    else if (!load_n)  model <= data_i;
    else if (en_p)     model <= model + 8'd1;
  end

  always @(negedge clk) begin
    if (!done) begin
      chk("R3 model count", count_o, model);
      chk("R6 model carry", {7'b0, carry_o}, {7'b0, model == 8'hFF});
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  initial begin
    clr_n = 1'b0; load_n = 1'b1; en_p = 1'b0; data_i = 8'h00;
    step(3);
    chk("R1 reset", count_o, 8'h00);
    clr_n = 1'b1;
    // R2: load with enables low
    load_n = 1'b0; data_i = 8'h3C; step(1);
    chk("R2 load", count_o, 8'h3C);
    load_n = 1'b1; en_p = 1'b1; step(5);
    chk("R3 count", count_o, 8'h41);
    en_p = 1'b0; step(3);
    chk("R4 hold", count_o, 8'h41);
    // R9: glitches between edges
    #3 load_n = 1'b0; data_i = 8'h99; #3 en_p = 1'b1; #2
    chk("R9 mid-cycle", count_o, 8'h41);
    load_n = 1'b1; en_p = 1'b0; step(1);
    chk("R9 next edge", count_o, 8'h41);
    // R7: carry into upper stage
    load_n = 1'b0; data_i = 8'h0E; step(1);
    load_n = 1'b1; en_p = 1'b1; step(2);
    chk("R7 stage rollover", count_o, 8'h10);
    en_p = 1'b0; load_n = 1'b0; data_i = 8'hF0; step(1);
    load_n = 1'b1;
    chk("R7 carry masked", {7'b0, carry_o}, 8'h00);
    load_n = 1'b0; data_i = 8'hFF; step(1);
    load_n = 1'b1; #1;
    chk("R6 carry without en_p", {7'b0, carry_o}, 8'h01);
    en_p = 1'b1; step(1);
    chk("R5 wrap", count_o, 8'h00);
    chk("R6 carry after wrap", {7'b0, carry_o}, 8'h00);
    // R1/R8: clear in mid-cycle, pending load must lose
    load_n = 1'b0; data_i = 8'h55; step(1);
    load_n = 1'b1; en_p = 1'b0;
    #4 clr_n = 1'b0; #1
    chk("R1 async clear", count_o, 8'h00);
    load_n = 1'b0; data_i = 8'hAA; step(1);
    chk("R8 clear beats load", count_o, 8'h00);
    clr_n = 1'b1; load_n = 1'b1; step(1);
    chk("R8 after release", count_o, 8'h00);
    // mixed run across many boundaries
    load_n = 1'b0; data_i = 8'hE7; step(1);
    for (int k = 0; k < 400; k++) begin
      load_n = (k % 53 != 17);
      en_p   = (k % 7 != 3);
      data_i = 8'(k * 29);
      step(1);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL R3 watchdog: got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule